// File: doc/BRIEF.md
# DSP Operand Address Generator

This block forms the effective address of a data-memory load or store for a DSP core. It also forms the post-update value of the base register. It keeps eight 32-bit address registers, eight 32-bit offset registers, and a pair of stack pointers. One stack pointer serves normal operation and the other serves exception handling. The `exc_state` input picks which stack pointer is active.

Every cycle, a mode code and register selects choose how the address is built. The address is formed in one of four ways:
- from a base register alone;
- from a base register plus a scaled index;
- from a base register plus an immediate displacement;
- from the active stack pointer and an immediate displacement.

Index and short offsets are scaled by the access size (byte, word, long, double long) before they are applied. All arithmetic is linear and wraps at 32 bits. The effective address is combinational. The single register write-back, which happens only in the post-increment mode, is committed on the clock edge. A register load port lets the core initialise any address register, offset register or stack pointer.

Top module: `opnd_addr_gen`

## Requirements
- R1: A synchronous active-low reset clears all address registers, offset registers and both stack pointers to zero.
- R2: Post-increment mode (`mode`=0) outputs `ea` = A[rn_sel]. It drives `wb_data` = A[rn_sel] + (O[rm_sel] << width) and `wb_idx` = rn_sel. When `upd`=1, `wb_en`=1 and A[rn_sel] takes `wb_data` at the clock edge. The offset register is never altered.
- R3: Offset-indexed mode (`mode`=1) outputs `ea` = A[rn_sel] + (O[0] << width). The index is always offset register 0, whatever `rm_sel` holds.
- R4: Register-indexed mode (`mode`=2) outputs `ea` = A[rn_sel] + (A[rm_sel] << width).
- R5: Short-displacement mode (`mode`=3) outputs `ea` = A[rn_sel] + (zero-extended `imm_short[2:0]` << width). Bits 5:3 of `imm_short` are ignored.
- R6: Word-displacement mode (`mode`=4) outputs `ea` = A[rn_sel] + sign-extended `imm_word`. The 15-bit value is a byte offset and is not scaled, so its range is -16384 to +16383.
- R7: Stack short mode (`mode`=5) outputs `ea` = SP − (zero-extended `imm_short` << s). The shift s is 1 when `width`=1 and 2 for every other width.
- R8: Stack word mode (`mode`=6) outputs `ea` = SP + sign-extended `imm_word`, with no scaling.
- R9: SP is the normal stack pointer when `exc_state`=0 and the exception stack pointer when `exc_state`=1. Neither stack-pointer mode modifies either stack pointer.
- R10: `wb_en` is 1 only in mode 0 with `upd`=1. In every other mode, `upd` is ignored and no register changes.
- R11: All sums and differences wrap modulo 2^32.
- R12: When `ld_en`=1, `ld_data` is written at the clock edge to a target chosen by `ld_kind`:
  - `ld_kind`=0 writes A[ld_idx];
  - `ld_kind`=1 writes O[ld_idx];
  - `ld_kind`=2 writes the stack pointer selected by `ld_idx[0]` (0 = normal, 1 = exception).
  
  A load to the same address register as a same-cycle write-back wins over the write-back.
- R13: Mode 7 is reserved. It outputs `ea` = 0 and writes nothing.
- R14: In the cycle of a post-increment write-back, all address computation reads the old register value. The new value appears from the next cycle.

Width codes: 0 byte, 1 word, 2 long, 3 double long (shift 0..3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Addressing mode code |
| width | input | 2 | Access size code, also the offset shift amount |
| rn_sel | input | 3 | Base address register select |
| rm_sel | input | 3 | Index register select (offset register in mode 0, address register in mode 2) |
| exc_state | input | 1 | 1 selects the exception stack pointer |
| imm_short | input | 6 | Unsigned short displacement field |
| imm_word | input | 15 | Signed byte displacement |
| upd | input | 1 | Post-increment update strobe |
| ld_en | input | 1 | Register load enable |
| ld_kind | input | 2 | Load target class |
| ld_idx | input | 3 | Load target index |
| ld_data | input | 32 | Load value |
| ea | output | 32 | Effective operand address |
| wb_en | output | 1 | Address register write-back enable |
| wb_idx | output | 3 | Write-back register index |
| wb_data | output | 32 | Write-back value |

## Verification
Each indexed mode is tried with positive and negative indices at all four widths. This separates correct shift amounts and sign handling from wrong ones. The displacement modes are driven at the 15-bit extremes 0x3FFF and 0x4000 to expose a missing sign extension. Short fields are driven with all ones to expose scaling or field-masking slips. The stack modes run with both values of `exc_state` against different pointer contents, which reveals a swapped bank. Post-increment is issued back-to-back on one register, with and without the strobe, and together with a competing load. This distinguishes old-value reads, missing commits and wrong write priority. A long run of random operations against a shadow model then covers mode mixtures.

// File: rtl/opag_pkg.sv
// Shared encodings for the operand address generator.
package opag_pkg;
    typedef enum logic [2:0] {
        M_POSTINC  = 3'd0,
        M_IDX_N0   = 3'd1,
        M_IDX_RM   = 3'd2,
        M_SHORT    = 3'd3,
        M_WORD     = 3'd4,
        M_SP_SHORT = 3'd5,
        M_SP_WORD  = 3'd6,
        M_RSVD     = 3'd7
    } mode_e;

    localparam logic [1:0] W_WORD  = 2'd1;

    localparam logic [1:0] LD_ADDR = 2'd0;
    localparam logic [1:0] LD_OFFS = 2'd1;
    localparam logic [1:0] LD_SP   = 2'd2;
endpackage

// File: rtl/opag_regfile.sv
// Address, offset and banked stack-pointer storage.
// Assumes: one load port and one write-back port; a load to the same
// address register beats the write-back. Reads are combinational, so a
// same-cycle reader sees the value from before the edge.
module opag_regfile
    import opag_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic [1:0]                ld_kind,
    input  logic [IW-1:0]             ld_idx,
    input  logic [AW-1:0]             ld_data,
    input  logic                      wb_en,
    input  logic [IW-1:0]             wb_idx,
    input  logic [AW-1:0]             wb_data,
    input  logic [IW-1:0]             rn_sel,
    input  logic [IW-1:0]             rm_sel,
    input  logic                      exc_state,
    output logic [AW-1:0]             rn_val,
    output logic [AW-1:0]             rm_val,
    output logic [AW-1:0]             ni_val,
    output logic [AW-1:0]             n0_val,
    output logic [AW-1:0]             sp_val,
    output logic [NREG-1:0][AW-1:0]   a_all,
    output logic [NREG-1:0][AW-1:0]   n_all,
    output logic [1:0][AW-1:0]        sp_all
);
    logic [NREG-1:0][AW-1:0] a_q;
    logic [NREG-1:0][AW-1:0] n_q;
    logic [1:0][AW-1:0]      sp_q;

    // Address registers: load first, then post-increment write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (ld_en && ld_kind == LD_ADDR && ld_idx == IW'(i))
                    a_q[i] <= ld_data;
                else if (wb_en && wb_idx == IW'(i))
                    a_q[i] <= wb_data;
            end
        end
    end

    // Offset registers: written only through the load port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (ld_en && ld_kind == LD_OFFS && ld_idx == IW'(i))
                    n_q[i] <= ld_data;
            end
        end
    end

    // Stack pointers: bank 0 normal, bank 1 exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (ld_en && ld_kind == LD_SP) begin
            sp_q[ld_idx[0]] <= ld_data;
        end
    end

    // Read muxes.
    always_comb begin
        rn_val = a_q[rn_sel];
        rm_val = a_q[rm_sel];
        ni_val = n_q[rm_sel];
        n0_val = n_q[0];
        sp_val = sp_q[exc_state];
    end

    assign a_all  = a_q;
    assign n_all  = n_q;
    assign sp_all = sp_q;
endmodule

// File: rtl/opag_offset.sv
// Selects and scales the offset for the current mode.
// Assumes: width code doubles as the shift amount; stack short mode
// shifts by 1 for word access and 2 otherwise; word displacements are
// byte offsets and are sign-extended, not scaled.
module opag_offset
    import opag_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SHW = 6,
    parameter int DW  = 15
) (
    input  mode_e            mode,
    input  logic [1:0]       width,
    input  logic [AW-1:0]    rm_val,
    input  logic [AW-1:0]    ni_val,
    input  logic [AW-1:0]    n0_val,
    input  logic [SHW-1:0]   imm_short,
    input  logic [DW-1:0]    imm_word,
    output logic [AW-1:0]    off,
    output logic             sub
);
    logic [AW-1:0] disp_sx;
    logic [AW-1:0] short3_zx;
    logic [AW-1:0] short_zx;
    logic [1:0]    sp_sh;

    // Extended immediates and stack scaling amount.
    always_comb begin
        disp_sx   = {{(AW-DW){imm_word[DW-1]}}, imm_word};
        short3_zx = AW'(imm_short[2:0]);
        short_zx  = AW'(imm_short);
        sp_sh     = (width == W_WORD) ? 2'd1 : 2'd2;
    end

    // Per-mode offset and direction.
    always_comb begin
        sub = 1'b0;
        unique case (mode)
            M_POSTINC:  off = ni_val << width;
            M_IDX_N0:   off = n0_val << width;
            M_IDX_RM:   off = rm_val << width;
            M_SHORT:    off = short3_zx << width;
            M_WORD:     off = disp_sx;
            M_SP_SHORT: begin off = short_zx << sp_sh; sub = 1'b1; end
            M_SP_WORD:  off = disp_sx;
            default:    off = '0;
        endcase
    end
endmodule

// File: rtl/opnd_addr_gen.sv
// Top level: effective address and post-increment write-back.
// Assumes: one shared adder/subtractor forms both the addressed sum and
// the write-back value; stack modes use the banked stack pointer as base.
module opnd_addr_gen
    import opag_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32,
    parameter int SHW  = 6,
    parameter int DW   = 15,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      mode,
    input  logic [1:0]      width,
    input  logic [IW-1:0]   rn_sel,
    input  logic [IW-1:0]   rm_sel,
    input  logic            exc_state,
    input  logic [SHW-1:0]  imm_short,
    input  logic [DW-1:0]   imm_word,
    input  logic            upd,
    input  logic            ld_en,
    input  logic [1:0]      ld_kind,
    input  logic [IW-1:0]   ld_idx,
    input  logic [AW-1:0]   ld_data,
    output logic [AW-1:0]   ea,
    output logic            wb_en,
    output logic [IW-1:0]   wb_idx,
    output logic [AW-1:0]   wb_data
);
    mode_e                   m;
    logic [AW-1:0]           rn_val, rm_val, ni_val, n0_val, sp_val;
    logic [NREG-1:0][AW-1:0] a_all, n_all;
    logic [1:0][AW-1:0]      sp_all;
    logic [AW-1:0]           off, base, sum;
    logic                    sub, use_sp;

    assign m = mode_e'(mode);

    opag_regfile #(.NREG(NREG), .AW(AW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_kind(ld_kind), .ld_idx(ld_idx), .ld_data(ld_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .rn_sel(rn_sel), .rm_sel(rm_sel), .exc_state(exc_state),
        .rn_val(rn_val), .rm_val(rm_val), .ni_val(ni_val), .n0_val(n0_val),
        .sp_val(sp_val), .a_all(a_all), .n_all(n_all), .sp_all(sp_all)
    );

    opag_offset #(.AW(AW), .SHW(SHW), .DW(DW)) u_off (
        .mode(m), .width(width), .rm_val(rm_val), .ni_val(ni_val),
        .n0_val(n0_val), .imm_short(imm_short), .imm_word(imm_word),
        .off(off), .sub(sub)
    );

    // Base select and the single shared adder.
    always_comb begin
        use_sp = (m == M_SP_SHORT) || (m == M_SP_WORD);
        base   = use_sp ? sp_val : rn_val;
        sum    = sub ? (base - off) : (base + off);
    end

    // Output steering: post-increment addresses the unmodified base.
    always_comb begin
        unique case (m)
            M_POSTINC: ea = rn_val;
            M_RSVD:    ea = '0;
            default:   ea = sum;
        endcase
        wb_en   = upd && (m == M_POSTINC);
        wb_idx  = rn_sel;
        wb_data = sum;
    end
endmodule

// File: rtl/opag_chk.sv
// Temporal checks on the address generator, bound to the top module.
module opag_chk #(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              mode,
    input  logic                    upd,
    input  logic                    ld_en,
    input  logic                    wb_en,
    input  logic [IW-1:0]           wb_idx,
    input  logic [AW-1:0]           wb_data,
    input  logic [AW-1:0]           ea,
    input  logic [AW-1:0]           rn_val,
    input  logic [NREG-1:0][AW-1:0] a_all,
    input  logic [NREG-1:0][AW-1:0] n_all,
    input  logic [1:0][AW-1:0]      sp_all
);
    // R2
    postinc_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |-> (ea == rn_val));
    // R2
    wb_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !ld_en) |=> (a_all[$past(wb_idx)] == $past(wb_data)));
    // R10
    wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (mode == 3'd0 && upd));
    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_en && !ld_en) |=> $stable(a_all));
    // R9
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(sp_all));
    // R2
    offs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(n_all));
    // R13
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd7) |-> (ea == '0 && !wb_en));
endmodule

bind opnd_addr_gen opag_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .upd(upd), .ld_en(ld_en),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .ea(ea),
    .rn_val(rn_val), .a_all(a_all), .n_all(n_all), .sp_all(sp_all)
);

// File: tb/tb_opnd_addr_gen.sv
// Scoreboard bench: the driver pushes expected results, the monitor
// pops and compares them at the falling edge of the same cycle.
module tb_opnd_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd7;
    logic [1:0]  width = 2'd0;
    logic [2:0]  rn_sel = 3'd0, rm_sel = 3'd0;
    logic        exc_state = 1'b0;
    logic [5:0]  imm_short = 6'd0;
    logic [14:0] imm_word = 15'd0;
    logic        upd = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_kind = 2'd0;
    logic [2:0]  ld_idx = 3'd0;
    logic [31:0] ld_data = 32'd0;
    logic [31:0] ea;
    logic        wb_en;
    logic [2:0]  wb_idx;
    logic [31:0] wb_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] ea;
        bit          wbe;
        logic [31:0] wbd;
        string       tag;
    } item_t;

    item_t q[$];

    logic [31:0] m_a [8];
    logic [31:0] m_n [8];
    logic [31:0] m_sp[2];

    always #5 clk = ~clk;

    opnd_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .width(width),
        .rn_sel(rn_sel), .rm_sel(rm_sel), .exc_state(exc_state),
        .imm_short(imm_short), .imm_word(imm_word), .upd(upd),
        .ld_en(ld_en), .ld_kind(ld_kind), .ld_idx(ld_idx), .ld_data(ld_data),
        .ea(ea), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    function automatic logic [31:0] sx15(input logic [14:0] v);
        return {{17{v[14]}}, v};
    endfunction

    // Reference model of the requirements.
    task automatic model(input logic [2:0] m, input logic [1:0] w,
                         input logic [2:0] rn, input logic [2:0] rm,
                         input logic [5:0] is, input logic [14:0] iw,
                         input bit ex, input bit u, output item_t it);
        logic [31:0] sum;
        sum = 32'd0;
        it.wbe = 1'b0;
        case (m)
            3'd0: sum = m_a[rn] + (m_n[rm] << w);
            3'd1: sum = m_a[rn] + (m_n[0] << w);
            3'd2: sum = m_a[rn] + (m_a[rm] << w);
            3'd3: sum = m_a[rn] + ({29'd0, is[2:0]} << w);
            3'd4: sum = m_a[rn] + sx15(iw);
            3'd5: sum = m_sp[ex] - ({26'd0, is} << ((w == 2'd1) ? 1 : 2));
            3'd6: sum = m_sp[ex] + sx15(iw);
            default: sum = 32'd0;
        endcase
        it.ea  = (m == 3'd0) ? m_a[rn] : sum;
        it.wbd = sum;
        it.wbe = (m == 3'd0) && u;
    endtask

    task automatic op(input logic [2:0] m, input logic [1:0] w,
                      input logic [2:0] rn, input logic [2:0] rm,
                      input logic [5:0] is, input logic [14:0] iw,
                      input bit ex, input bit u, input string tag);
        item_t it;
        @(posedge clk); #1;
        mode = m; width = w; rn_sel = rn; rm_sel = rm; imm_short = is;
        imm_word = iw; exc_state = ex; upd = u; ld_en = 1'b0;
        model(m, w, rn, rm, is, iw, ex, u, it);
        it.tag = tag;
        q.push_back(it);
        if (it.wbe) m_a[rn] = it.wbd;
    endtask

    // Load with an optional competing post-increment on the same cycle.
    task automatic ld(input logic [1:0] k, input logic [2:0] idx,
                      input logic [31:0] d, input bit pinc, input string tag);
        item_t it;
        @(posedge clk); #1;
        ld_en = 1'b1; ld_kind = k; ld_idx = idx; ld_data = d;
        mode = pinc ? 3'd0 : 3'd7; upd = pinc; rn_sel = idx; rm_sel = 3'd1;
        width = 2'd0; exc_state = 1'b0;
        model(mode, 2'd0, idx, 3'd1, 6'd0, 15'd0, 1'b0, pinc, it);
        it.tag = tag;
        q.push_back(it);
        if (it.wbe) m_a[idx] = it.wbd;
        case (k)
            2'd0: m_a[idx] = d;
            2'd1: m_n[idx] = d;
            default: m_sp[idx[0]] = d;
        endcase
    endtask

    // Monitor: compare in the middle of each cycle.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                checks++;
                if (ea !== it.ea) begin
                    errors++;
                    $display("FAIL %s: ea actual %h expected %h", it.tag, ea, it.ea);
                end
                checks++;
                if (wb_en !== it.wbe) begin
                    errors++;
                    $display("FAIL %s: wb_en actual %b expected %b", it.tag, wb_en, it.wbe);
                end
                if (it.wbe) begin
                    checks++;
                    if (wb_data !== it.wbd) begin
                        errors++;
                        $display("FAIL %s: wb_data actual %h expected %h", it.tag, wb_data, it.wbd);
                    end
                end
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_a[i] = 0; m_n[i] = 0; end
        m_sp[0] = 0; m_sp[1] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: everything reads zero after reset
        op(3'd4, 2'd0, 3'd5, 3'd0, 6'd0, 15'd0, 1'b0, 1'b0, "R1 addr reset");
        op(3'd6, 2'd0, 3'd0, 3'd0, 6'd0, 15'd0, 1'b1, 1'b0, "R1 sp reset");
        op(3'd0, 2'd0, 3'd3, 3'd3, 6'd0, 15'd0, 1'b0, 1'b0, "R1 offset reset");

        // R12: loads of each class
        for (int i = 0; i < 8; i++) begin
            ld(2'd0, 3'(i), 32'h1000_0000 + 32'(i) * 32'h110, 1'b0, "R12 load addr");
        end
        ld(2'd1, 3'd0, 32'hFFFF_FFFD, 1'b0, "R12 load offs");
        ld(2'd1, 3'd1, 32'd5, 1'b0, "R12 load offs");
        ld(2'd1, 3'd2, 32'hFFFF_FFF0, 1'b0, "R12 load offs");
        ld(2'd2, 3'd0, 32'h0000_8000, 1'b0, "R12 load spn");
        ld(2'd2, 3'd1, 32'h0004_0000, 1'b0, "R12 load spe");
        ld(2'd0, 3'd6, 32'hFFFF_FFF8, 1'b0, "R12 load addr");

        // R2/R14: post-increment at every width, back to back on one register
        for (int w = 0; w < 4; w++) begin
            op(3'd0, 2'(w), 3'd2, 3'd1, 6'd0, 15'd0, 1'b0, 1'b1, "R2 R14 postinc pos");
            op(3'd0, 2'(w), 3'd2, 3'd2, 6'd0, 15'd0, 1'b0, 1'b1, "R2 postinc neg");
        end
        op(3'd0, 2'd3, 3'd4, 3'd1, 6'd0, 15'd0, 1'b0, 1'b0, "R10 postinc no upd");
        op(3'd2, 2'd0, 3'd4, 3'd7, 6'd0, 15'd0, 1'b0, 1'b0, "R10 reg unchanged");
        op(3'd0, 2'd0, 3'd0, 3'd1, 6'd0, 15'd0, 1'b0, 1'b0, "R2 offset kept");

        // R3, R4: indexed modes at each width
        for (int w = 0; w < 4; w++) begin
            op(3'd1, 2'(w), 3'd3, 3'd5, 6'd0, 15'd0, 1'b0, 1'b1, "R3 idx n0");
            op(3'd2, 2'(w), 3'd1, 3'd6, 6'd0, 15'd0, 1'b0, 1'b1, "R4 idx rm neg");
            op(3'd2, 2'(w), 3'd1, 3'd7, 6'd0, 15'd0, 1'b0, 1'b0, "R4 idx rm");
        end

        // R5: short displacement, upper field bits ignored
        for (int w = 0; w < 4; w++) begin
            op(3'd3, 2'(w), 3'd5, 3'd0, 6'h3F, 15'd0, 1'b0, 1'b1, "R5 short");
            op(3'd3, 2'(w), 3'd5, 3'd0, 6'h05, 15'd0, 1'b0, 1'b0, "R5 short");
        end

        // R6, R8, R9: word displacement extremes, both stack banks
        op(3'd4, 2'd3, 3'd7, 3'd0, 6'd0, 15'h3FFF, 1'b0, 1'b0, "R6 word max");
        op(3'd4, 2'd2, 3'd7, 3'd0, 6'd0, 15'h4000, 1'b0, 1'b0, "R6 word min");
        op(3'd4, 2'd0, 3'd7, 3'd0, 6'd0, 15'h7FFF, 1'b0, 1'b0, "R6 word -1");
        op(3'd6, 2'd0, 3'd0, 3'd0, 6'd0, 15'h4000, 1'b0, 1'b0, "R8 R9 spword normal");
        op(3'd6, 2'd3, 3'd0, 3'd0, 6'd0, 15'h3FFF, 1'b1, 1'b1, "R8 R9 spword exc");

        // R7, R9: stack short at every width code, both banks
        for (int w = 0; w < 4; w++) begin
            op(3'd5, 2'(w), 3'd0, 3'd0, 6'h3F, 15'd0, 1'b0, 1'b1, "R7 R9 spshort normal");
            op(3'd5, 2'(w), 3'd0, 3'd0, 6'h1F, 15'd0, 1'b1, 1'b0, "R7 R9 spshort exc");
        end
        op(3'd6, 2'd0, 3'd0, 3'd0, 6'd0, 15'd0, 1'b0, 1'b0, "R9 sp unchanged");

        // R11: wraparound
        op(3'd4, 2'd0, 3'd6, 3'd0, 6'd0, 15'h0010, 1'b0, 1'b0, "R11 wrap up");
        ld(2'd2, 3'd0, 32'd4, 1'b0, "R12 load spn");
        op(3'd5, 2'd2, 3'd0, 3'd0, 6'h3F, 15'd0, 1'b0, 1'b0, "R11 wrap down");
        op(3'd0, 2'd3, 3'd6, 3'd1, 6'd0, 15'd0, 1'b0, 1'b1, "R11 postinc wrap");
        op(3'd4, 2'd0, 3'd6, 3'd0, 6'd0, 15'd0, 1'b0, 1'b0, "R11 wrap stored");

        // R12: load beats a same-cycle write-back
        ld(2'd0, 3'd3, 32'hCAFE_0000, 1'b1, "R12 load vs wb");
        op(3'd4, 2'd0, 3'd3, 3'd0, 6'd0, 15'd0, 1'b0, 1'b0, "R12 load wins");

        // R13: reserved mode
        op(3'd7, 2'd2, 3'd1, 3'd1, 6'h3F, 15'h7FFF, 1'b1, 1'b1, "R13 reserved");

        // Mixed random traffic against the model
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 7) == 0)
                ld(2'($urandom_range(0, 2)), 3'($urandom), $urandom, 1'($urandom), "R12 random load");
            else
                op(3'($urandom), 2'($urandom), 3'($urandom), 3'($urandom),
                   6'($urandom), 15'($urandom), 1'($urandom), 1'($urandom), "R2 random op");
        end

        @(posedge clk); #1;
        ld_en = 1'b0; upd = 1'b0; mode = 3'd7;
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule